// File: doc/BRIEF.md
# Fetch Group Builder with Micro-Op Sequencing

This block assembles one group of instruction entries per clock from a cache line that already sits in a buffer outside the block. It begins at the word addressed by the current program counter and walks forward through the line. Each word is classified by its top two bits. A macro-op word is expanded into a run of micro-ops, tracked by a micro-op counter that lives next to the PC and next-PC registers. Because of that counter, a group may end in the middle of a macro-op, and the next group picks up at the following micro-op.

Each group holds up to `WIDTH` entries. Every entry carries its PC, next-PC, micro-op index, raw word and a sequence number. The branch predictor sits outside the block. For each output slot it supplies a taken bit and a target, and these matter only when that slot holds a control word.

Two redirect channels can reload the PC state: a high-priority one and a low-priority one. A quiesce word or a fetch fault parks the block until the next redirect. A fetch whose line tag does not match the PC waits for the line to arrive.

Top module: `fetch_group_builder`

## Requirements
- R1: After reset no entry is valid, and the first group starts at `RESET_PC` with next-PC `RESET_PC+4`, micro-op index 0 and sequence number 0.
- R2: A group starts at word index `pc[OFF_BITS-1:2]` of the line. A word's kind is its bits [31:30]: 00 plain, 01 control, 10 macro-op, 11 quiesce.
- R3: A group stops when any of these occurs: the word index passes the last word of the line, `WIDTH` entries have been emitted, or a control word predicted taken has been emitted. Valid entries always fill the lowest slots.
- R4: A plain word, or the last micro-op of a macro-op, moves PC to the old next-PC, adds 4 to next-PC, clears the micro-op index and advances the word index by one.
- R5: A macro-op holds its micro-op count in bits [UPC_W-1:0], and a count of 0 or 1 means a single micro-op. Every micro-op except the last increments only the micro-op index, so PC, next-PC and word index stay put and the next entry repeats the same PC.
- R6: A control word in slot i uses `pred_taken[i]` and `pred_target[i]` and always clears the micro-op index. If predicted taken, PC becomes the target, next-PC becomes target+4 and the group ends. Otherwise the word steps like a plain word.
- R7: A quiesce word is emitted, steps PC like a plain word and ends the group. After it no group is emitted until a redirect arrives.
- R8: After a group without a fault, PC, next-PC and micro-op index hold the values that follow the last emitted entry, and the next group starts from them.
- R9: Sequence numbers rise by one for each emitted entry, across groups, and wrap at 2^SEQ_W.
- R10: A redirect loads PC, next-PC and micro-op index and emits nothing in its cycle. It cancels a pending line wait and spends exactly one cycle in a squashing state before fetch resumes. The high-priority channel wins when both channels fire.
- R11: A low-priority redirect that arrives while the block is in the squashing state is ignored.
- R12: A fetch with `fetch_fault` set emits one entry only, in slot 0. That entry has word 0, `grp_fault` set, the current PC, next-PC and micro-op index, and one sequence number. PC state is left unchanged, and the block parks until a redirect.
- R13: A fetch whose line is invalid, or whose line tag differs from `pc[AW-1:OFF_BITS]`, emits nothing and waits. Fetch resumes in the cycle after a matching line is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | Request a group this cycle |
| fetch_fault | input | 1 | Translation fault on this fetch |
| line_valid | input | 1 | Line buffer holds data |
| line_tag | input | AW-OFF_BITS | Address of the buffered line |
| line_words | input | LINE_WORDS*32 | Buffered line, word 0 in the low bits |
| pred_taken | input | WIDTH | Predictor taken bit per slot |
| pred_target | input | WIDTH*AW | Predictor target per slot |
| rd_hi_valid | input | 1 | High-priority redirect |
| rd_hi_pc | input | AW | Redirect PC |
| rd_hi_npc | input | AW | Redirect next-PC |
| rd_hi_upc | input | UPC_W | Redirect micro-op index |
| rd_lo_valid | input | 1 | Low-priority redirect |
| rd_lo_pc | input | AW | Redirect PC |
| rd_lo_npc | input | AW | Redirect next-PC |
| rd_lo_upc | input | UPC_W | Redirect micro-op index |
| grp_valid | output | WIDTH | Entry valid per slot |
| grp_pc | output | WIDTH*AW | Entry PC |
| grp_npc | output | WIDTH*AW | Entry next-PC |
| grp_upc | output | WIDTH*UPC_W | Entry micro-op index |
| grp_word | output | WIDTH*32 | Entry raw word |
| grp_seq | output | WIDTH*SEQ_W | Entry sequence number |
| grp_fault | output | 1 | Slot 0 carries a fault no-op |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a redirect and a fetch request: the bench raises both together and expects an empty group, with the next real group starting at the redirect PC. The second pair is the two redirect channels, either firing together or with the low-priority one arriving during the squashing cycle of the high-priority one. The bench judges these by where the following group starts. A sweep over line contents, start words, start micro-op indices and every predictor pattern runs against an arithmetic model of the stepping rules, and it catches a group boundary that coincides with a macro-op boundary or with a taken branch.

// File: rtl/fgb_pkg.sv
package fgb_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT    = 2'd1,
    ST_SQUASH  = 2'd2,
    ST_HALT    = 2'd3
  } fstate_e;

  typedef enum logic [1:0] {
    K_PLAIN   = 2'd0,
    K_CTRL    = 2'd1,
    K_MACRO   = 2'd2,
    K_QUIESCE = 2'd3
  } kind_e;

  localparam int WORD_BYTES = 4;

endpackage

// File: rtl/fgb_slot_stage.sv
module fgb_slot_stage
  import fgb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_WORDS = 8,
  parameter int UPC_W      = 4,
  localparam int IDX_W     = $clog2(LINE_WORDS),
  localparam int OFFC_W    = IDX_W + 1
) (
  input  logic [AW-1:0]            in_pc,
  input  logic [AW-1:0]            in_npc,
  input  logic [UPC_W-1:0]         in_upc,
  input  logic [OFFC_W-1:0]        in_off,
  input  logic                     in_done,
  input  logic [LINE_WORDS*32-1:0] line_words,
  input  logic                     pred_taken,
  input  logic [AW-1:0]            pred_target,
  output logic [AW-1:0]            out_pc,
  output logic [AW-1:0]            out_npc,
  output logic [UPC_W-1:0]         out_upc,
  output logic [OFFC_W-1:0]        out_off,
  output logic                     out_done,
  output logic                     emit,
  output logic [31:0]              emit_word,
  output logic                     quiesce
);

  logic [IDX_W-1:0] idx;
  logic             in_range;
  kind_e            kind;
  logic [UPC_W-1:0] ucnt;
  logic             last_uop;

  assign idx       = in_off[IDX_W-1:0];
  assign in_range  = in_off < OFFC_W'(LINE_WORDS);
  assign emit_word = line_words[{idx, 5'd0} +: 32];
  assign emit      = !in_done && in_range;
  assign kind      = kind_e'(emit_word[31:30]);
  assign ucnt      = emit_word[UPC_W-1:0];
  assign last_uop  = (ucnt <= UPC_W'(1)) || (in_upc >= (ucnt - UPC_W'(1)));

  always_comb begin
    out_pc   = in_pc;
    out_npc  = in_npc;
    out_upc  = in_upc;
    out_off  = in_off;
    out_done = in_done || !in_range;
    quiesce  = 1'b0;
    if (emit) begin
      unique case (kind)
        K_PLAIN: begin
          out_pc  = in_npc;
          out_npc = in_npc + AW'(WORD_BYTES);
          out_upc = '0;
          out_off = in_off + OFFC_W'(1);
        end
        K_CTRL: begin
          out_upc = '0;
          out_off = in_off + OFFC_W'(1);
          if (pred_taken) begin
            out_pc   = pred_target;
            out_npc  = pred_target + AW'(WORD_BYTES);
            out_done = 1'b1;
          end else begin
            out_pc  = in_npc;
            out_npc = in_npc + AW'(WORD_BYTES);
          end
        end
        K_MACRO: begin
          if (last_uop) begin
            out_pc  = in_npc;
            out_npc = in_npc + AW'(WORD_BYTES);
            out_upc = '0;
            out_off = in_off + OFFC_W'(1);
          end else begin
            out_upc = in_upc + UPC_W'(1);
          end
        end
        K_QUIESCE: begin
          out_pc   = in_npc;
          out_npc  = in_npc + AW'(WORD_BYTES);
          out_upc  = '0;
          out_off  = in_off + OFFC_W'(1);
          out_done = 1'b1;
          quiesce  = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fgb_group_builder.sv
module fgb_group_builder
  import fgb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_WORDS = 8,
  parameter int WIDTH      = 4,
  parameter int UPC_W      = 4,
  localparam int OFF_BITS  = $clog2(LINE_WORDS * WORD_BYTES),
  localparam int IDX_W     = $clog2(LINE_WORDS),
  localparam int OFFC_W    = IDX_W + 1,
  localparam int CNT_W     = $clog2(WIDTH + 1)
) (
  input  logic [AW-1:0]            pc,
  input  logic [AW-1:0]            npc,
  input  logic [UPC_W-1:0]         upc,
  input  logic [LINE_WORDS*32-1:0] line_words,
  input  logic [WIDTH-1:0]         pred_taken,
  input  logic [WIDTH*AW-1:0]      pred_target,
  output logic [WIDTH-1:0]         slot_valid,
  output logic [WIDTH*AW-1:0]      slot_pc,
  output logic [WIDTH*AW-1:0]      slot_npc,
  output logic [WIDTH*UPC_W-1:0]   slot_upc,
  output logic [WIDTH*32-1:0]      slot_word,
  output logic [CNT_W-1:0]         slot_cnt,
  output logic [AW-1:0]            end_pc,
  output logic [AW-1:0]            end_npc,
  output logic [UPC_W-1:0]         end_upc,
  output logic                     quiesce_seen
);

  logic [AW-1:0]     pc_c   [WIDTH+1];
  logic [AW-1:0]     npc_c  [WIDTH+1];
  logic [UPC_W-1:0]  upc_c  [WIDTH+1];
  logic [OFFC_W-1:0] off_c  [WIDTH+1];
  logic              done_c [WIDTH+1];
  logic [WIDTH-1:0]  q_slot;

  assign pc_c[0]   = pc;
  assign npc_c[0]  = npc;
  assign upc_c[0]  = upc;
  assign off_c[0]  = {1'b0, pc[OFF_BITS-1:2]};
  assign done_c[0] = 1'b0;

  for (genvar s = 0; s < WIDTH; s++) begin : g_slot
    fgb_slot_stage #(
      .AW(AW), .LINE_WORDS(LINE_WORDS), .UPC_W(UPC_W)
    ) i_stage (
      .in_pc       (pc_c[s]),
      .in_npc      (npc_c[s]),
      .in_upc      (upc_c[s]),
      .in_off      (off_c[s]),
      .in_done     (done_c[s]),
      .line_words  (line_words),
      .pred_taken  (pred_taken[s]),
      .pred_target (pred_target[s*AW +: AW]),
      .out_pc      (pc_c[s+1]),
      .out_npc     (npc_c[s+1]),
      .out_upc     (upc_c[s+1]),
      .out_off     (off_c[s+1]),
      .out_done    (done_c[s+1]),
      .emit        (slot_valid[s]),
      .emit_word   (slot_word[s*32 +: 32]),
      .quiesce     (q_slot[s])
    );
    assign slot_pc[s*AW +: AW]        = pc_c[s];
    assign slot_npc[s*AW +: AW]       = npc_c[s];
    assign slot_upc[s*UPC_W +: UPC_W] = upc_c[s];
  end

  assign slot_cnt     = CNT_W'($countones(slot_valid));
  assign end_pc       = pc_c[WIDTH];
  assign end_npc      = npc_c[WIDTH];
  assign end_upc      = upc_c[WIDTH];
  assign quiesce_seen = |q_slot;

endmodule

// File: rtl/fgb_fetch_ctl.sv
module fgb_fetch_ctl
  import fgb_pkg::*;
#(
  parameter int AW                 = 32,
  parameter int LINE_WORDS         = 8,
  parameter int WIDTH              = 4,
  parameter int UPC_W              = 4,
  parameter int SEQ_W              = 8,
  parameter logic [AW-1:0] RESET_PC = '0,
  localparam int OFF_BITS          = $clog2(LINE_WORDS * WORD_BYTES),
  localparam int TAG_W             = AW - OFF_BITS,
  localparam int CNT_W             = $clog2(WIDTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_en,
  input  logic                   fetch_fault,
  input  logic                   line_valid,
  input  logic [TAG_W-1:0]       line_tag,
  input  logic                   rd_hi_valid,
  input  logic [AW-1:0]          rd_hi_pc,
  input  logic [AW-1:0]          rd_hi_npc,
  input  logic [UPC_W-1:0]       rd_hi_upc,
  input  logic                   rd_lo_valid,
  input  logic [AW-1:0]          rd_lo_pc,
  input  logic [AW-1:0]          rd_lo_npc,
  input  logic [UPC_W-1:0]       rd_lo_upc,
  input  logic [WIDTH-1:0]       b_valid,
  input  logic [WIDTH*AW-1:0]    b_pc,
  input  logic [WIDTH*AW-1:0]    b_npc,
  input  logic [WIDTH*UPC_W-1:0] b_upc,
  input  logic [WIDTH*32-1:0]    b_word,
  input  logic [CNT_W-1:0]       b_cnt,
  input  logic [AW-1:0]          b_end_pc,
  input  logic [AW-1:0]          b_end_npc,
  input  logic [UPC_W-1:0]       b_end_upc,
  input  logic                   b_quiesce,
  output logic [AW-1:0]          pc_q,
  output logic [AW-1:0]          npc_q,
  output logic [UPC_W-1:0]       upc_q,
  output logic [WIDTH-1:0]       grp_valid,
  output logic [WIDTH*AW-1:0]    grp_pc,
  output logic [WIDTH*AW-1:0]    grp_npc,
  output logic [WIDTH*UPC_W-1:0] grp_upc,
  output logic [WIDTH*32-1:0]    grp_word,
  output logic [WIDTH*SEQ_W-1:0] grp_seq,
  output logic                   grp_fault
);

  fstate_e          state_q, state_d;
  logic [AW-1:0]    pc_d, npc_d;
  logic [UPC_W-1:0] upc_d;
  logic             pc_en;
  logic [SEQ_W-1:0] seq_q, seq_d;

  logic             lo_taken, any_redir, line_hit;
  logic             run_fetch, fault_emit, grp_emit, data_en;

  logic [WIDTH-1:0]       valid_d;
  logic [WIDTH*AW-1:0]    opc_d, onpc_d;
  logic [WIDTH*UPC_W-1:0] oupc_d;
  logic [WIDTH*32-1:0]    oword_d;
  logic [WIDTH*SEQ_W-1:0] oseq_d;
  logic                   fault_d;

  // Redirect arbitration and fetch qualification
  assign lo_taken   = rd_lo_valid && (state_q != ST_SQUASH);
  assign any_redir  = rd_hi_valid || lo_taken;
  assign line_hit   = line_valid && (line_tag == pc_q[AW-1:OFF_BITS]);
  assign run_fetch  = !any_redir && (state_q == ST_RUN) && fetch_en;
  assign fault_emit = run_fetch && fetch_fault;
  assign grp_emit   = run_fetch && !fetch_fault && line_hit;
  assign data_en    = fault_emit || grp_emit;

  // Next state
  always_comb begin
    state_d = state_q;
    if (any_redir) begin
      state_d = ST_SQUASH;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (fault_emit)                  state_d = ST_HALT;
          else if (run_fetch && !line_hit) state_d = ST_WAIT;
          else if (grp_emit && b_quiesce)  state_d = ST_HALT;
        end
        ST_WAIT:   if (line_hit) state_d = ST_RUN;
        ST_SQUASH: state_d = ST_RUN;
        ST_HALT:   state_d = ST_HALT;
        default:   state_d = ST_RUN;
      endcase
    end
  end

  // Architectural PC triple and sequence counter
  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    npc_d = npc_q;
    upc_d = upc_q;
    if (rd_hi_valid) begin
      pc_en = 1'b1;
      pc_d  = rd_hi_pc;
      npc_d = rd_hi_npc;
      upc_d = rd_hi_upc;
    end else if (lo_taken) begin
      pc_en = 1'b1;
      pc_d  = rd_lo_pc;
      npc_d = rd_lo_npc;
      upc_d = rd_lo_upc;
    end else if (grp_emit) begin
      pc_en = 1'b1;
      pc_d  = b_end_pc;
      npc_d = b_end_npc;
      upc_d = b_end_upc;
    end
  end

  always_comb begin
    seq_d = seq_q;
    if (grp_emit)        seq_d = seq_q + SEQ_W'(b_cnt);
    else if (fault_emit) seq_d = seq_q + SEQ_W'(1);
  end

  // Output group next values
  always_comb begin
    valid_d = '0;
    fault_d = 1'b0;
    opc_d   = b_pc;
    onpc_d  = b_npc;
    oupc_d  = b_upc;
    oword_d = b_word;
    for (int i = 0; i < WIDTH; i++) begin
      oseq_d[i*SEQ_W +: SEQ_W] = seq_q + SEQ_W'(i);
    end
    if (fault_emit) begin
      valid_d          = WIDTH'(1);
      fault_d          = 1'b1;
      opc_d[AW-1:0]    = pc_q;
      onpc_d[AW-1:0]   = npc_q;
      oupc_d[UPC_W-1:0] = upc_q;
      oword_d[31:0]    = '0;
    end else if (grp_emit) begin
      valid_d = b_valid;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      pc_q      <= RESET_PC;
      npc_q     <= RESET_PC + AW'(WORD_BYTES);
      upc_q     <= '0;
      seq_q     <= '0;
      grp_valid <= '0;
      grp_fault <= 1'b0;
    end else begin
      state_q   <= state_d;
      seq_q     <= seq_d;
      grp_valid <= valid_d;
      grp_fault <= fault_d;
      if (pc_en) begin
        pc_q  <= pc_d;
        npc_q <= npc_d;
        upc_q <= upc_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_pc   <= '0;
      grp_npc  <= '0;
      grp_upc  <= '0;
      grp_word <= '0;
      grp_seq  <= '0;
    end else if (data_en) begin
      grp_pc   <= opc_d;
      grp_npc  <= onpc_d;
      grp_upc  <= oupc_d;
      grp_word <= oword_d;
      grp_seq  <= oseq_d;
    end
  end

  // Checks on the group leaving the block
  AST_VALID_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid & (grp_valid + WIDTH'(1))) == '0); // R3

  AST_FAULT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_fault |-> (grp_valid == WIDTH'(1))); // R12

  AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_valid || rd_lo_valid) |=> (grp_valid == '0)); // R10

  AST_LO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SQUASH && rd_lo_valid && !rd_hi_valid)
    |=> (pc_q == $past(pc_q) && upc_q == $past(upc_q))); // R11

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |=> (grp_valid == '0)); // R7

  for (genvar i = 1; i < WIDTH; i++) begin : g_uop_chk
    AST_UOP_SAME_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_valid[i] && grp_upc[i*UPC_W +: UPC_W] != '0)
      |-> (grp_pc[i*AW +: AW] == grp_pc[(i-1)*AW +: AW])); // R5
  end

endmodule

// File: rtl/fetch_group_builder.sv
module fetch_group_builder
  import fgb_pkg::*;
#(
  parameter int AW                 = 32,
  parameter int LINE_WORDS         = 8,
  parameter int WIDTH              = 4,
  parameter int UPC_W              = 4,
  parameter int SEQ_W              = 8,
  parameter logic [AW-1:0] RESET_PC = '0,
  localparam int OFF_BITS          = $clog2(LINE_WORDS * WORD_BYTES),
  localparam int TAG_W             = AW - OFF_BITS,
  localparam int CNT_W             = $clog2(WIDTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetch_en,
  input  logic                     fetch_fault,
  input  logic                     line_valid,
  input  logic [TAG_W-1:0]         line_tag,
  input  logic [LINE_WORDS*32-1:0] line_words,
  input  logic [WIDTH-1:0]         pred_taken,
  input  logic [WIDTH*AW-1:0]      pred_target,
  input  logic                     rd_hi_valid,
  input  logic [AW-1:0]            rd_hi_pc,
  input  logic [AW-1:0]            rd_hi_npc,
  input  logic [UPC_W-1:0]         rd_hi_upc,
  input  logic                     rd_lo_valid,
  input  logic [AW-1:0]            rd_lo_pc,
  input  logic [AW-1:0]            rd_lo_npc,
  input  logic [UPC_W-1:0]         rd_lo_upc,
  output logic [WIDTH-1:0]         grp_valid,
  output logic [WIDTH*AW-1:0]      grp_pc,
  output logic [WIDTH*AW-1:0]      grp_npc,
  output logic [WIDTH*UPC_W-1:0]   grp_upc,
  output logic [WIDTH*32-1:0]      grp_word,
  output logic [WIDTH*SEQ_W-1:0]   grp_seq,
  output logic                     grp_fault
);

  logic [AW-1:0]          pc_q, npc_q;
  logic [UPC_W-1:0]       upc_q;
  logic [WIDTH-1:0]       b_valid;
  logic [WIDTH*AW-1:0]    b_pc, b_npc;
  logic [WIDTH*UPC_W-1:0] b_upc;
  logic [WIDTH*32-1:0]    b_word;
  logic [CNT_W-1:0]       b_cnt;
  logic [AW-1:0]          b_end_pc, b_end_npc;
  logic [UPC_W-1:0]       b_end_upc;
  logic                   b_quiesce;

  fgb_group_builder #(
    .AW(AW), .LINE_WORDS(LINE_WORDS), .WIDTH(WIDTH), .UPC_W(UPC_W)
  ) i_builder (
    .pc           (pc_q),
    .npc          (npc_q),
    .upc          (upc_q),
    .line_words   (line_words),
    .pred_taken   (pred_taken),
    .pred_target  (pred_target),
    .slot_valid   (b_valid),
    .slot_pc      (b_pc),
    .slot_npc     (b_npc),
    .slot_upc     (b_upc),
    .slot_word    (b_word),
    .slot_cnt     (b_cnt),
    .end_pc       (b_end_pc),
    .end_npc      (b_end_npc),
    .end_upc      (b_end_upc),
    .quiesce_seen (b_quiesce)
  );

  fgb_fetch_ctl #(
    .AW(AW), .LINE_WORDS(LINE_WORDS), .WIDTH(WIDTH), .UPC_W(UPC_W),
    .SEQ_W(SEQ_W), .RESET_PC(RESET_PC)
  ) i_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_en    (fetch_en),
    .fetch_fault (fetch_fault),
    .line_valid  (line_valid),
    .line_tag    (line_tag),
    .rd_hi_valid (rd_hi_valid),
    .rd_hi_pc    (rd_hi_pc),
    .rd_hi_npc   (rd_hi_npc),
    .rd_hi_upc   (rd_hi_upc),
    .rd_lo_valid (rd_lo_valid),
    .rd_lo_pc    (rd_lo_pc),
    .rd_lo_npc   (rd_lo_npc),
    .rd_lo_upc   (rd_lo_upc),
    .b_valid     (b_valid),
    .b_pc        (b_pc),
    .b_npc       (b_npc),
    .b_upc       (b_upc),
    .b_word      (b_word),
    .b_cnt       (b_cnt),
    .b_end_pc    (b_end_pc),
    .b_end_npc   (b_end_npc),
    .b_end_upc   (b_end_upc),
    .b_quiesce   (b_quiesce),
    .pc_q        (pc_q),
    .npc_q       (npc_q),
    .upc_q       (upc_q),
    .grp_valid   (grp_valid),
    .grp_pc      (grp_pc),
    .grp_npc     (grp_npc),
    .grp_upc     (grp_upc),
    .grp_word    (grp_word),
    .grp_seq     (grp_seq),
    .grp_fault   (grp_fault)
  );

endmodule

// File: tb/test_fetch_group_builder.sv
`timescale 1ns/1ps
module test_fetch_group_builder;

  localparam int AW = 32, LW = 8, W = 4, UW = 4, SW = 8;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic            fetch_en, fetch_fault, line_valid;
  logic [26:0]     line_tag;
  logic [LW*32-1:0] line_words;
  logic [W-1:0]    pred_taken;
  logic [W*AW-1:0] pred_target;
  logic            rd_hi_valid, rd_lo_valid;
  logic [31:0]     rd_hi_pc, rd_hi_npc, rd_lo_pc, rd_lo_npc;
  logic [3:0]      rd_hi_upc, rd_lo_upc;
  logic [W-1:0]    grp_valid;
  logic [W*AW-1:0] grp_pc, grp_npc;
  logic [W*UW-1:0] grp_upc;
  logic [W*32-1:0] grp_word;
  logic [W*SW-1:0] grp_seq;
  logic            grp_fault;

  fetch_group_builder i_fetch_group_builder (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_fault(fetch_fault),
    .line_valid(line_valid), .line_tag(line_tag), .line_words(line_words),
    .pred_taken(pred_taken), .pred_target(pred_target),
    .rd_hi_valid(rd_hi_valid), .rd_hi_pc(rd_hi_pc), .rd_hi_npc(rd_hi_npc), .rd_hi_upc(rd_hi_upc),
    .rd_lo_valid(rd_lo_valid), .rd_lo_pc(rd_lo_pc), .rd_lo_npc(rd_lo_npc), .rd_lo_upc(rd_lo_upc),
    .grp_valid(grp_valid), .grp_pc(grp_pc), .grp_npc(grp_npc), .grp_upc(grp_upc),
    .grp_word(grp_word), .grp_seq(grp_seq), .grp_fault(grp_fault)
  );

  int checks = 0, errors = 0;
  string cur_req;

  // Reference model state: 0 run, 1 wait, 2 squash, 3 halt
  int          m_st;
  logic [31:0] m_pc, m_npc;
  logic [3:0]  m_upc;
  logic [7:0]  m_seq;
  logic        e_valid [W];
  logic [31:0] e_pc [W], e_npc [W], e_word [W];
  logic [3:0]  e_upc [W];
  logic [7:0]  e_seq [W];
  logic        e_fault;

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_step();
    for (int s = 0; s < W; s++) e_valid[s] = 1'b0;
    e_fault = 1'b0;
    if (rd_hi_valid) begin
      m_pc = rd_hi_pc; m_npc = rd_hi_npc; m_upc = rd_hi_upc; m_st = 2; return;
    end
    if (rd_lo_valid && m_st != 2) begin
      m_pc = rd_lo_pc; m_npc = rd_lo_npc; m_upc = rd_lo_upc; m_st = 2; return;
    end
    case (m_st)
      0: if (fetch_en) begin
        if (fetch_fault) begin
          e_valid[0] = 1'b1; e_pc[0] = m_pc; e_npc[0] = m_npc; e_upc[0] = m_upc;
          e_word[0] = 32'h0; e_seq[0] = m_seq; e_fault = 1'b1;
          m_seq++; m_st = 3;
        end else if (!(line_valid && line_tag == m_pc[31:5])) begin
          m_st = 1;
        end else begin
          int off = int'(m_pc[4:2]);
          logic [31:0] p = m_pc, n = m_npc;
          int u = int'(m_upc);
          bit done = 0;
          for (int s = 0; s < W; s++) begin
            if (!done && off < LW) begin
              logic [31:0] w = line_words[off*32 +: 32];
              e_valid[s] = 1'b1; e_pc[s] = p; e_npc[s] = n; e_upc[s] = 4'(u);
              e_word[s] = w; e_seq[s] = m_seq; m_seq++;
              case (w[31:30])
                2'd0: begin p = n; n = n + 4; u = 0; off++; end
                2'd1: begin
                  u = 0; off++;
                  if (pred_taken[s]) begin
                    p = pred_target[s*32 +: 32]; n = p + 4; done = 1;
                  end else begin p = n; n = n + 4; end
                end
                2'd2: begin
                  int cnt = int'(w[3:0]);
                  if (cnt <= 1 || u >= cnt - 1) begin p = n; n = n + 4; u = 0; off++; end
                  else u++;
                end
                default: begin p = n; n = n + 4; u = 0; off++; done = 1; m_st = 3; end
              endcase
            end
          end
          m_pc = p; m_npc = n; m_upc = 4'(u);
        end
      end
      1: if (line_valid && line_tag == m_pc[31:5]) m_st = 0;
      2: m_st = 0;
      default: ;
    endcase
  endtask

  task automatic compare();
    chk(grp_fault === e_fault, "fault", 32'(grp_fault), 32'(e_fault));
    for (int s = 0; s < W; s++) begin
      chk(grp_valid[s] === e_valid[s], $sformatf("slot%0d valid", s), 32'(grp_valid[s]), 32'(e_valid[s]));
      if (e_valid[s] && grp_valid[s]) begin
        chk(grp_pc[s*32 +: 32] === e_pc[s], $sformatf("slot%0d pc", s), grp_pc[s*32 +: 32], e_pc[s]);
        chk(grp_npc[s*32 +: 32] === e_npc[s], $sformatf("slot%0d npc", s), grp_npc[s*32 +: 32], e_npc[s]);
        chk(grp_upc[s*4 +: 4] === e_upc[s], $sformatf("slot%0d upc", s), 32'(grp_upc[s*4 +: 4]), 32'(e_upc[s]));
        chk(grp_word[s*32 +: 32] === e_word[s], $sformatf("slot%0d word", s), grp_word[s*32 +: 32], e_word[s]);
        chk(grp_seq[s*8 +: 8] === e_seq[s], $sformatf("slot%0d seq", s), 32'(grp_seq[s*8 +: 8]), 32'(e_seq[s]));
      end
    end
  endtask

  // One clock: model, edge, sample at the falling edge, clear one-shot inputs
  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    fetch_en = 0; fetch_fault = 0; rd_hi_valid = 0; rd_lo_valid = 0;
  endtask

  task automatic redirect_hi(input logic [31:0] pc, input logic [3:0] upc);
    rd_hi_valid = 1; rd_hi_pc = pc; rd_hi_npc = pc + 4; rd_hi_upc = upc;
    step();
  endtask

  task automatic fetch();
    fetch_en = 1;
    step();
  endtask

  function automatic logic [31:0] pat_word(input int pat, input int i);
    logic [31:0] pl = 32'h0000_0100 | 32'(i);
    logic [31:0] ct = 32'h4000_0200 | 32'(i);
    case (pat)
      0: return pl;
      1: case (i) 0: return pl; 1: return 32'h8000_0003; 2: return ct; 3: return pl;
                  4: return 32'h8000_0002; 5: return ct; 6: return pl; default: return 32'h8000_0001; endcase
      2: case (i) 0: return ct; 1: return ct; 2: return 32'h8000_0005; 3: return pl;
                  4: return ct; 5: return 32'h8000_0000; default: return pl; endcase
      default: case (i) 1: return 32'hC000_0000; 2: return 32'h8000_0002; 3: return ct;
                  6: return 32'hC000_0000; 7: return ct; default: return pl; endcase
    endcase
  endfunction

  task automatic load_line(input int pat, input logic [31:0] base);
    for (int i = 0; i < LW; i++) line_words[i*32 +: 32] = pat_word(pat, i);
    line_tag = base[31:5];
    line_valid = 1;
    for (int i = 0; i < W; i++) pred_target[i*32 +: 32] = base + 32'(((i * 3 + 1) % LW) * 4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; fetch_en = 0; fetch_fault = 0; rd_hi_valid = 0; rd_lo_valid = 0;
    rd_hi_pc = 0; rd_hi_npc = 0; rd_hi_upc = 0; rd_lo_pc = 0; rd_lo_npc = 0; rd_lo_upc = 0;
    pred_taken = 0;
    m_st = 0; m_pc = 0; m_npc = 4; m_upc = 0; m_seq = 0;
    load_line(1, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state, then first group from the reset PC
    cur_req = "R1";
    chk(grp_valid === '0, "valid after reset", 32'(grp_valid), 32'h0);
    fetch();
    fetch();

    // R2 R3 R4 R5 R6 R7 R8 R9: sweep of lines, start words, micro indices, predictor patterns
    cur_req = "R2/R3/R4/R5/R6/R7/R8/R9";
    for (int pat = 0; pat < 4; pat++) begin
      load_line(pat, BASE);
      for (int sw = 0; sw < LW; sw++)
        for (int su = 0; su < 3; su++)
          for (int bp = 0; bp < 16; bp++) begin
            pred_taken = 4'(bp);
            redirect_hi(BASE + 32'(sw * 4), 4'(su));
            step();
            fetch();
            fetch();
            fetch();
          end
    end
    pred_taken = 0;

    // R7: a quiesce parks fetch until a redirect
    cur_req = "R7";
    load_line(3, BASE);
    redirect_hi(BASE, 0); step();
    fetch(); fetch(); fetch();
    redirect_hi(BASE + 8, 0); step(); fetch();

    // R13: line miss then matching line arrives
    cur_req = "R13";
    load_line(0, BASE);
    redirect_hi(BASE + 32'h40, 0); step();
    fetch(); fetch(); step();
    load_line(0, BASE + 32'h40); step(); fetch();

    // R10: redirect cancels a pending wait; redirect together with a fetch request
    cur_req = "R10";
    load_line(1, BASE);
    redirect_hi(BASE + 32'h80, 0); step();
    fetch();
    redirect_hi(BASE + 4, 1); step(); fetch();
    fetch_en = 1; redirect_hi(BASE + 12, 0); fetch();
    rd_lo_valid = 1; rd_lo_pc = BASE + 16; rd_lo_npc = BASE + 20; rd_lo_upc = 0; step();
    step(); fetch();
    rd_lo_valid = 1; rd_lo_pc = BASE + 8; rd_lo_npc = BASE + 12; rd_lo_upc = 0;
    redirect_hi(BASE + 24, 0); step(); fetch();

    // R11: low-priority redirect during the squashing cycle is ignored
    cur_req = "R11";
    redirect_hi(BASE + 4, 0);
    rd_lo_valid = 1; rd_lo_pc = BASE + 20; rd_lo_npc = BASE + 24; rd_lo_upc = 2; step();
    fetch();

    // R12: fault entry, held PC, parked until redirect
    cur_req = "R12";
    redirect_hi(BASE + 8, 0); step();
    fetch_fault = 1; fetch();
    fetch(); fetch();
    redirect_hi(BASE + 8, 0); step(); fetch();

    // R9: sequence wrap over many groups
    cur_req = "R9";
    load_line(0, BASE);
    for (int k = 0; k < 80; k++) begin
      redirect_hi(BASE, 0); step(); fetch(); fetch();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule